// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register with Loopback Collision Test

This block holds the basic control word of an Ethernet PHY management space and turns its fields into the signals the rest of the PHY acts on. A small register bus (address, write strobe, write data, combinational read data) reaches one 16-bit word at a parameterised address. From that word the block issues a one-cycle restart request to the auto-negotiation engine and keeps a pending flag that clears itself when the engine reports completion. It also resolves the effective duplex mode from the manual setting, the negotiated result and the loopback state. When loopback is on, it can fake a collision on the MII collision line in response to transmit enable.

The block runs on the MII nibble clock, so one clock is four bit times. With the collision test active, the collision output rises a parameterised number of clocks (1 to 128, so never later than 512 bit times) after transmit enable goes high. It falls on the first clock edge that sees transmit enable low.

Top module: `phy_ctrl_reg`

## Requirements
- R1: After reset every control bit reads 0, the restart pulse and collision output are 0, and the effective duplex is half (0).
- R2: At the control address, bit 14 (loopback), bit 12 (auto-negotiation enable), bit 8 (manual full duplex) and bit 7 (collision test enable) are written by a write strobe and read back unchanged. Any other address reads 0, and a write to it changes nothing.
- R3: Bits 15, 13, 11, 10 and 6 to 0 always read 0, whatever was written.
- R4: A write at the control address with bit 9 and bit 12 both 1 sets the restart flag (bit 9), and the restart output is 1 for exactly the following cycle.
- R5: The restart flag clears on the clock edge where the done input is 1, unless a restart write hits in that same cycle, in which case the flag stays set.
- R6: While auto-negotiation enable is 0 (including a write that clears it), the restart flag is 0. A write of bit 9 = 1 with bit 12 = 0 produces neither the flag nor a pulse.
- R7: With loopback 0 and auto-negotiation 0, the effective duplex equals bit 8 (1 full, 0 half).
- R8: With loopback 0 and auto-negotiation 1, the effective duplex equals the negotiated-duplex input, and bit 8 has no effect.
- R9: With loopback 1, the effective duplex is full (1), regardless of bit 8 and of the negotiated input.
- R10: With loopback and collision test both set and transmit enable held high, the collision output becomes 1 after the COL_DLY-th clock edge that samples transmit enable high, and stays 1 while transmit enable stays high.
- R11: The collision output is 0 after any edge that samples transmit enable low, or that samples loopback or collision test clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MII nibble clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational on address) |
| an_done | input | 1 | Auto-negotiation reports it has initialised |
| an_result_full | input | 1 | Negotiated duplex, 1 = full |
| mii_tx_en | input | 1 | MII transmit enable |
| an_restart | output | 1 | One-cycle restart request to auto-negotiation |
| duplex_full | output | 1 | Effective duplex, 1 = full |
| mii_col | output | 1 | Collision output of the loopback collision test |

## Verification
The hardest situations to reach are a restart write that lands in the same cycle as the done indication, and a write that clears auto-negotiation enable while a restart is still pending. Each needs the bus and the engine's done input lined up in one exact cycle, so both are driven as directed sequences. A second hard case is a transmit-enable burst long enough to pass the collision delay while loopback and the test bit are both set. The random phase keeps transmit enable in long runs and biases writes toward the control address so that such bursts happen many times. The random phase also changes the mode bits during those bursts.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;
    localparam int WORD_W    = 16;
    localparam int POS_LOOP  = 14;
    localparam int POS_ANEN  = 12;
    localparam int POS_RSTAN = 9;
    localparam int POS_FDX   = 8;
    localparam int POS_CTEST = 7;

    typedef struct packed {
        logic loopback;
        logic an_en;
        logic an_rst;
        logic full_dpx;
        logic col_test;
    } ctrl_fields_t;
endpackage

// File: rtl/phy_ctrl_regs.sv
module phy_ctrl_regs
    import phy_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int CTRL_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              an_done_i,
    output ctrl_fields_t      fields_o,
    output logic              restart_pulse_o,
    output logic [WORD_W-1:0] rdata_o
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CTRL_ADDR);

    typedef struct packed {
        ctrl_fields_t f;
        logic         pulse;
    } regs_state_t;

    regs_state_t st_d, st_q;
    logic        hit;
    logic        wr_hit;
    logic        set_rst;
    logic        unused_wbits;

    assign hit          = (addr_i == HIT_ADDR);
    assign wr_hit       = wr_i && hit;
    assign set_rst      = wr_hit && wdata_i[POS_RSTAN] && wdata_i[POS_ANEN];
    assign unused_wbits = ^{wdata_i[15], wdata_i[13], wdata_i[11:10], wdata_i[6:0]};

    always_comb begin
        st_d       = st_q;
        st_d.pulse = set_rst;
        if (wr_hit) begin
            st_d.f.loopback = wdata_i[POS_LOOP];
            st_d.f.an_en    = wdata_i[POS_ANEN];
            st_d.f.full_dpx = wdata_i[POS_FDX];
            st_d.f.col_test = wdata_i[POS_CTEST];
        end
        if (set_rst) begin
            st_d.f.an_rst = 1'b1;
        end else if (!st_d.f.an_en) begin
            st_d.f.an_rst = 1'b0;
        end else if (an_done_i) begin
            st_d.f.an_rst = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (hit) begin
            rdata_o[POS_LOOP]  = st_q.f.loopback;
            rdata_o[POS_ANEN]  = st_q.f.an_en;
            rdata_o[POS_RSTAN] = st_q.f.an_rst;
            rdata_o[POS_FDX]   = st_q.f.full_dpx;
            rdata_o[POS_CTEST] = st_q.f.col_test;
        end
    end

    assign fields_o        = st_q.f;
    assign restart_pulse_o = st_q.pulse;

    // R6
    rst_needs_anen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.f.an_en |-> !st_q.f.an_rst);

    // R4
    pulse_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |-> st_q.f.an_rst);

    // R5
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (an_done_i && !wr_i) |=> !st_q.f.an_rst);

    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_o[6:0] == 7'd0) && !rdata_o[15] && !rdata_o[13] && (rdata_o[11:10] == 2'd0));
endmodule

// File: rtl/phy_ctrl_duplex.sv
module phy_ctrl_duplex
    import phy_ctrl_pkg::*;
(
    input  ctrl_fields_t fields_i,
    input  logic         an_full_i,
    output logic         full_o
);
    logic unused_fields;
    assign unused_fields = fields_i.an_rst ^ fields_i.col_test;

    always_comb begin
        if (fields_i.loopback) begin
            full_o = 1'b1;
        end else if (fields_i.an_en) begin
            full_o = an_full_i;
        end else begin
            full_o = fields_i.full_dpx;
        end
    end
endmodule

// File: rtl/phy_ctrl_coltest.sv
module phy_ctrl_coltest #(
    parameter int COL_DLY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic tx_en_i,
    output logic col_o
);
    localparam int            CNT_W = (COL_DLY < 2) ? 1 : $clog2(COL_DLY);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(COL_DLY - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             col;
    } col_state_t;

    col_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active_i || !tx_en_i) begin
            st_d.cnt = '0;
            st_d.col = 1'b0;
        end else if (st_q.cnt == LAST) begin
            st_d.col = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_o = st_q.col;

    // R11
    col_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_i |=> !col_o);

    // R11
    col_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !col_o);

    // R10
    col_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_o) |-> ($past(tx_en_i) && $past(active_i)));

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
    import phy_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int CTRL_ADDR = 0,
    parameter int COL_DLY   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              an_done,
    input  logic              an_result_full,
    input  logic              mii_tx_en,
    output logic              an_restart,
    output logic              duplex_full,
    output logic              mii_col
);
    ctrl_fields_t fields;
    logic         test_active;

    phy_ctrl_regs #(
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR)
    ) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .addr_i         (reg_addr),
        .wr_i           (reg_wr),
        .wdata_i        (reg_wdata),
        .an_done_i      (an_done),
        .fields_o       (fields),
        .restart_pulse_o(an_restart),
        .rdata_o        (reg_rdata)
    );

    phy_ctrl_duplex u_dpx (
        .fields_i (fields),
        .an_full_i(an_result_full),
        .full_o   (duplex_full)
    );

    assign test_active = fields.loopback && fields.col_test;

    phy_ctrl_coltest #(
        .COL_DLY(COL_DLY)
    ) u_col (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(test_active),
        .tx_en_i (mii_tx_en),
        .col_o   (mii_col)
    );

    // R4
    single_pulse_on_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (an_restart && !reg_wr) |=> !an_restart);
endmodule

// File: tb/sim_phy_ctrl_reg.sv
`timescale 1ns/1ps
module sim_phy_ctrl_reg;
    localparam int AW  = 5;
    localparam int DLY = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          an_done = 1'b0;
    logic          an_result_full = 1'b0;
    logic          mii_tx_en = 1'b0;
    logic          an_restart, duplex_full, mii_col;

    always #2.5 clk = ~clk;

    phy_ctrl_reg #(.ADDR_W(AW), .CTRL_ADDR(0), .COL_DLY(DLY)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .an_done(an_done),
        .an_result_full(an_result_full), .mii_tx_en(mii_tx_en),
        .an_restart(an_restart), .duplex_full(duplex_full), .mii_col(mii_col)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    bit m_lb, m_ane, m_rst, m_dpx, m_ct, m_pulse, m_col;
    int m_cnt;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_rd(input logic [AW-1:0] a);
        logic [15:0] v = '0;
        if (a == '0) begin
            v[14] = m_lb; v[12] = m_ane; v[9] = m_rst; v[8] = m_dpx; v[7] = m_ct;
        end
        return v;
    endfunction

    function automatic logic exp_dpx(input logic res);
        if (m_lb) return 1'b1;
        if (m_ane) return res;
        return m_dpx;
    endfunction

    task automatic check_all();
        logic [15:0] e;
        logic [15:0] rmask;
        rmask = 16'hACFF ^ 16'h0080;
        e = exp_rd(reg_addr);
        chk("R3 reserved bits", reg_rdata & 16'hAC7F, 16'h0000);
        chk("R2 field bits", reg_rdata & 16'h5180, e & 16'h5180);
        chk("R4 R5 R6 restart flag", {15'd0, reg_rdata[9]}, {15'd0, e[9]});
        chk("R4 restart pulse", {15'd0, an_restart}, {15'd0, m_pulse});
        if (m_lb)       chk("R9 duplex in loopback", {15'd0, duplex_full}, {15'd0, exp_dpx(an_result_full)});
        else if (m_ane) chk("R8 negotiated duplex",  {15'd0, duplex_full}, {15'd0, exp_dpx(an_result_full)});
        else            chk("R7 manual duplex",      {15'd0, duplex_full}, {15'd0, exp_dpx(an_result_full)});
        chk("R10 R11 collision", {15'd0, mii_col}, {15'd0, m_col});
        if (rmask == 16'h0) n_chk++;
    endtask

    task automatic step(input logic [AW-1:0] a, input logic w, input logic [15:0] d,
                        input logic dn, input logic res, input logic tx);
        bit wr_hit, set_r, act;
        @(negedge clk);
        reg_addr = a; reg_wr = w; reg_wdata = d;
        an_done = dn; an_result_full = res; mii_tx_en = tx;
        #1;
        check_all();
        @(posedge clk);
        act = m_lb && m_ct;
        if (!act || !tx) begin
            m_cnt = 0; m_col = 1'b0;
        end else if (m_cnt == DLY - 1) begin
            m_col = 1'b1;
        end else begin
            m_cnt++;
        end
        wr_hit = w && (a == '0);
        set_r  = wr_hit && d[9] && d[12];
        m_pulse = set_r;
        if (wr_hit) begin
            m_lb = d[14]; m_ane = d[12]; m_dpx = d[8]; m_ct = d[7];
        end
        if (set_r) m_rst = 1'b1;
        else if (!m_ane) m_rst = 1'b0;
        else if (dn) m_rst = 1'b0;
    endtask

    task automatic idle(input int n, input logic tx);
        for (int i = 0; i < n; i++) step('0, 1'b0, 16'h0, 1'b0, 1'b0, tx);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        m_lb = 0; m_ane = 0; m_rst = 0; m_dpx = 0; m_ct = 0; m_pulse = 0; m_col = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        an_result_full = 1'b1;
        #1;
        // R1 reset state
        chk("R1 reset read", reg_rdata, 16'h0000);
        chk("R1 reset pulse", {15'd0, an_restart}, 16'h0);
        chk("R1 reset collision", {15'd0, mii_col}, 16'h0);
        chk("R1 reset duplex half", {15'd0, duplex_full}, 16'h0);
        rst_n = 1'b1;

        // R3: all ones written, reserved bits stay 0
        step('0, 1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0);
        idle(2, 1'b0);
        // R6: restart requested with auto-negotiation off
        step('0, 1'b1, 16'h0200, 1'b0, 1'b0, 1'b0);
        idle(2, 1'b0);
        // R6: write clearing enable drops a pending restart
        step('0, 1'b1, 16'h1200, 1'b0, 1'b0, 1'b0);
        step('0, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0);
        idle(1, 1'b0);
        // R4/R5: restart, then done clears it
        step('0, 1'b1, 16'h1200, 1'b0, 1'b1, 1'b0);
        idle(3, 1'b0);
        step('0, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0);
        idle(1, 1'b0);
        // R5: restart write in the same cycle as done keeps the flag
        step('0, 1'b1, 16'h1200, 1'b1, 1'b0, 1'b0);
        idle(2, 1'b0);
        // R2: write to another address ignored
        step(5'd3, 1'b1, 16'h4180, 1'b0, 1'b0, 1'b0);
        step(5'd3, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
        // R7 manual duplex
        step('0, 1'b1, 16'h0100, 1'b0, 1'b0, 1'b0);
        idle(1, 1'b0);
        // R9 loopback forces full; R10 collision burst
        step('0, 1'b1, 16'h4080, 1'b0, 1'b0, 1'b0);
        idle(DLY + 4, 1'b1);
        idle(3, 1'b0);
        // R11: test bit cleared during burst
        idle(DLY + 2, 1'b1);
        step('0, 1'b1, 16'h4000, 1'b0, 1'b0, 1'b1);
        idle(3, 1'b1);
        idle(1, 1'b0);

        begin
            logic tx = 1'b0;
            for (int i = 0; i < 6000; i++) begin
                logic [AW-1:0] a;
                logic [15:0]   d;
                logic          w;
                a = ($urandom % 5 == 0) ? AW'($urandom) : '0;
                w = ($urandom % 9 == 0);
                d = 16'($urandom);
                if ((i / 500) % 2 == 1) d = d | 16'h4080;
                if ($urandom % 20 == 0) tx = ~tx;
                step(a, w, d, ($urandom % 7 == 0), 1'($urandom), tx);
            end
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule